// File: doc/BRIEF.md
# Message-Unit Outbound-Post Interrupt Registers

This block holds the interrupt status and mask for the outbound side of a PCI message-passing unit. A single input tells it whether the outbound post queue holds anything. The block turns that into a status bit. When the interrupt is not masked, it also pulls a physical active-low interrupt line. The queue, the bus protocol and address translation sit outside the block.

The same two bits can be reached three ways. One is a 32-bit register window that decodes relative to a programmable message-unit base. The other two are 8-bit internal register apertures, one for the host side and one for the local side. Each aperture also exposes a general interrupt-configuration register, where the mask bit appears with inverted sense, and a general interrupt-status register, where the status bit is repeated. A mode input turns message-unit operation on. That input also changes how the base-register offsets in the apertures decode.

Each access port is a simple synchronous port with address, byte enable, write strobe, write data and registered read data.

Top module: `msgu_irq_regs`

## Requirements
- R1: After reset the status and mask bits are 0, `int0_n` is 1, and every aperture base register is 0. At aperture offset 0x40 the inverted enable (bit 3) reads 1.
- R2: The status bit is bit 3, reads 1 while `post_nonempty` is high and 0 once it drops, and follows the input with one clock of delay. It reads the same at window offset 0x30 and at aperture offsets 0x30 and 0x44.
- R3: `int0_n` is 0 exactly when the queue was non-empty and the mask bit was 0 at the previous clock edge. Otherwise it is 1. The mask never alters the status bit.
- R4: A window write to offset 0x34 with byte enable bit 0 set loads the mask from write-data bit 3. Without that byte enable the write does nothing. All window bits other than bit 3 read 0.
- R5: Aperture offset 0x34 holds the mask in bit 3. Aperture offset 0x40 holds its inverse in bit 3. A write through any of these views changes the one shared bit, and every view shows the change.
- R6: Writes to the status bit are ignored in every view (window 0x30, aperture 0x30 and 0x44).
- R7: The window responds only when the mode input is 1 and address bits [15:8] equal the message-unit base. Any other access reads 0, and its writes are ignored.
- R8: With the mode input at 0, aperture offsets 0x10, 0x14 and 0x18 are the I/O base, the second memory base and the second memory map. With the mode input at 1, offset 0x10 is the message-unit base and 0x18 is the I/O base. Offset 0x14 then reads 0 and ignores writes, and the hidden registers keep their values.
- R9: When mask writes collide in one cycle, the host aperture wins over the window, and the window wins over the local aperture. When base-register writes collide, the host aperture wins over the local aperture.
- R10: Read data on each port shows the register selected by the address presented before the last clock edge. It does not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mu_en | input | 1 | Message-unit mode enable |
| post_nonempty | input | 1 | Outbound post queue holds at least one entry |
| win_addr | input | 16 | Window address: base in [15:8], offset in [7:0] |
| win_be | input | 4 | Window byte enables |
| win_we | input | 1 | Window write strobe |
| win_wdata | input | 32 | Window write data |
| win_rdata | output | 32 | Window read data, registered |
| hst_addr | input | 8 | Host aperture byte offset |
| hst_be | input | 1 | Host aperture byte enable |
| hst_we | input | 1 | Host aperture write strobe |
| hst_wdata | input | 8 | Host aperture write data |
| hst_rdata | output | 8 | Host aperture read data, registered |
| loc_addr | input | 8 | Local aperture byte offset |
| loc_be | input | 1 | Local aperture byte enable |
| loc_we | input | 1 | Local aperture write strobe |
| loc_wdata | input | 8 | Local aperture write data |
| loc_rdata | output | 8 | Local aperture read data, registered |
| int0_n | output | 1 | Active-low interrupt line 0 |

## Verification
The queue input is raised and lowered with the mask both clear and set. This separates a status bit that follows the queue level from one that latches, and an interrupt that honours the mask from one that ignores it. Mask writes enter through each view in turn and are read back through a different one, so a lost inversion or a missing alias shows up. Simultaneous writes from all three ports carry conflicting values, so only the stated priority yields the expected mask. The mode input is toggled around base-register writes to expose a wrong offset remap or a hidden register that gets overwritten.

// File: rtl/msgu_pkg.sv
package msgu_pkg;

    localparam int REG_W    = 8;
    localparam int POST_BIT = 3;
    localparam int APT_AW   = 8;

    localparam logic [7:0] OFS_STAT  = 8'h30;
    localparam logic [7:0] OFS_MASK  = 8'h34;
    localparam logic [7:0] OFS_ICFG  = 8'h40;
    localparam logic [7:0] OFS_ISTAT = 8'h44;
    localparam logic [7:0] OFS_BASE0 = 8'h10;
    localparam logic [7:0] OFS_BASE1 = 8'h14;
    localparam logic [7:0] OFS_BASE2 = 8'h18;

    typedef enum logic [3:0] {
        RS_NONE,
        RS_STAT,
        RS_MASK,
        RS_ICFG,
        RS_ISTAT,
        RS_IO,
        RS_MUB,
        RS_M1B,
        RS_M1M
    } apt_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] io_base;
        logic [REG_W-1:0] mu_base;
        logic [REG_W-1:0] m1_base;
        logic [REG_W-1:0] m1_map;
        logic             mask;
        logic             stat;
    } regs_t;

    typedef struct packed {
        logic             mask_we;
        logic             mask_val;
        logic             io_we;
        logic             mub_we;
        logic             m1b_we;
        logic             m1m_we;
        logic [REG_W-1:0] data;
    } wreq_t;

    function automatic logic [REG_W-1:0] post_byte(input logic b);
        logic [REG_W-1:0] v;
        v = '0;
        v[POST_BIT] = b;
        return v;
    endfunction

    function automatic apt_sel_e apt_decode(input logic [APT_AW-1:0] off, input logic mode);
        apt_sel_e s;
        case (off)
            OFS_STAT:  s = RS_STAT;
            OFS_MASK:  s = RS_MASK;
            OFS_ICFG:  s = RS_ICFG;
            OFS_ISTAT: s = RS_ISTAT;
            OFS_BASE0: s = mode ? RS_MUB  : RS_IO;
            OFS_BASE1: s = mode ? RS_NONE : RS_M1B;
            OFS_BASE2: s = mode ? RS_IO   : RS_M1M;
            default:   s = RS_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [REG_W-1:0] apt_read(input regs_t r, input apt_sel_e s);
        logic [REG_W-1:0] v;
        case (s)
            RS_STAT, RS_ISTAT: v = post_byte(r.stat);
            RS_MASK:           v = post_byte(r.mask);
            RS_ICFG:           v = post_byte(!r.mask);
            RS_IO:             v = r.io_base;
            RS_MUB:            v = r.mu_base;
            RS_M1B:            v = r.m1_base;
            RS_M1M:            v = r.m1_map;
            default:           v = '0;
        endcase
        return v;
    endfunction

    function automatic logic [REG_W-1:0] pick_byte(
        input logic [REG_W-1:0] cur,
        input logic             we_a,
        input logic [REG_W-1:0] d_a,
        input logic             we_b,
        input logic [REG_W-1:0] d_b
    );
        if (we_a)      return d_a;
        else if (we_b) return d_b;
        return cur;
    endfunction

endpackage

// File: rtl/msgu_apt_port.sv
module msgu_apt_port
    import msgu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mu_en,
    input  logic [APT_AW-1:0] addr,
    input  logic              be,
    input  logic              we,
    input  logic [REG_W-1:0]  wdata,
    input  regs_t             regs,
    output wreq_t             req,
    output logic [REG_W-1:0]  rdata
);

    apt_sel_e sel;

    assign sel = apt_decode(addr, mu_en);

    always_comb begin
        req      = '0;
        req.data = wdata;
        if (we && be) begin
            case (sel)
                RS_MASK: begin
                    req.mask_we  = 1'b1;
                    req.mask_val = wdata[POST_BIT];
                end
                RS_ICFG: begin
                    req.mask_we  = 1'b1;
                    req.mask_val = !wdata[POST_BIT];
                end
                RS_IO:   req.io_we  = 1'b1;
                RS_MUB:  req.mub_we = 1'b1;
                RS_M1B:  req.m1b_we = 1'b1;
                RS_M1M:  req.m1m_we = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= apt_read(regs, sel);
    end

endmodule

// File: rtl/msgu_win_port.sv
module msgu_win_port
    import msgu_pkg::*;
#(
    parameter int OFS_W = 8,
    parameter int DW    = 32,
    localparam int AW   = OFS_W + REG_W,
    localparam int BEW  = DW / 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           mu_en,
    input  logic [AW-1:0]  addr,
    input  logic [BEW-1:0] be,
    input  logic           we,
    input  logic [DW-1:0]  wdata,
    input  regs_t          regs,
    output wreq_t          req,
    output logic [DW-1:0]  rdata
);

    logic             hit;
    logic [OFS_W-1:0] off;
    logic             sel_stat;
    logic             sel_mask;

    assign off      = addr[OFS_W-1:0];
    assign hit      = mu_en && (addr[OFS_W +: REG_W] == regs.mu_base);
    assign sel_stat = hit && (off == OFS_W'(OFS_STAT));
    assign sel_mask = hit && (off == OFS_W'(OFS_MASK));

    always_comb begin
        req      = '0;
        req.data = wdata[REG_W-1:0];
        if (we && sel_mask && be[POST_BIT/8]) begin
            req.mask_we  = 1'b1;
            req.mask_val = wdata[POST_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           rdata <= '0;
        else if (sel_stat) rdata <= DW'(post_byte(regs.stat));
        else if (sel_mask) rdata <= DW'(post_byte(regs.mask));
        else               rdata <= '0;
    end

endmodule

// File: rtl/msgu_reg_core.sv
module msgu_reg_core
    import msgu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  post_nonempty,
    input  wreq_t hreq,
    input  wreq_t wreq,
    input  wreq_t lreq,
    output regs_t regs,
    output logic  int0_n
);

    regs_t r_q;
    regs_t r_d;

    always_comb begin
        r_d      = r_q;
        r_d.stat = post_nonempty;
        if (hreq.mask_we)      r_d.mask = hreq.mask_val;
        else if (wreq.mask_we) r_d.mask = wreq.mask_val;
        else if (lreq.mask_we) r_d.mask = lreq.mask_val;
        r_d.io_base = pick_byte(r_q.io_base, hreq.io_we,  hreq.data, lreq.io_we,  lreq.data);
        r_d.mu_base = pick_byte(r_q.mu_base, hreq.mub_we, hreq.data, lreq.mub_we, lreq.data);
        r_d.m1_base = pick_byte(r_q.m1_base, hreq.m1b_we, hreq.data, lreq.m1b_we, lreq.data);
        r_d.m1_map  = pick_byte(r_q.m1_map,  hreq.m1m_we, hreq.data, lreq.m1m_we, lreq.data);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q    <= '0;
            int0_n <= 1'b1;
        end else begin
            r_q    <= r_d;
            int0_n <= !(post_nonempty && !r_q.mask);
        end
    end

    assign regs = r_q;

endmodule

// File: rtl/msgu_irq_regs.sv
module msgu_irq_regs
    import msgu_pkg::*;
#(
    parameter int WIN_OFS_W = 8,
    parameter int WIN_DW    = 32,
    localparam int WIN_AW   = WIN_OFS_W + REG_W,
    localparam int WIN_BEW  = WIN_DW / 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mu_en,
    input  logic               post_nonempty,
    input  logic [WIN_AW-1:0]  win_addr,
    input  logic [WIN_BEW-1:0] win_be,
    input  logic               win_we,
    input  logic [WIN_DW-1:0]  win_wdata,
    output logic [WIN_DW-1:0]  win_rdata,
    input  logic [APT_AW-1:0]  hst_addr,
    input  logic               hst_be,
    input  logic               hst_we,
    input  logic [REG_W-1:0]   hst_wdata,
    output logic [REG_W-1:0]   hst_rdata,
    input  logic [APT_AW-1:0]  loc_addr,
    input  logic               loc_be,
    input  logic               loc_we,
    input  logic [REG_W-1:0]   loc_wdata,
    output logic [REG_W-1:0]   loc_rdata,
    output logic               int0_n
);

    localparam int NAPT = 2;

    regs_t             regs;
    wreq_t             win_req;
    wreq_t             apt_req   [NAPT];
    logic [APT_AW-1:0] apt_addr  [NAPT];
    logic              apt_be    [NAPT];
    logic              apt_we    [NAPT];
    logic [REG_W-1:0]  apt_wdata [NAPT];
    logic [REG_W-1:0]  apt_rdata [NAPT];

    // index 0 is the host side, index 1 the local side
    assign apt_addr[0]  = hst_addr;
    assign apt_be[0]    = hst_be;
    assign apt_we[0]    = hst_we;
    assign apt_wdata[0] = hst_wdata;
    assign apt_addr[1]  = loc_addr;
    assign apt_be[1]    = loc_be;
    assign apt_we[1]    = loc_we;
    assign apt_wdata[1] = loc_wdata;
    assign hst_rdata    = apt_rdata[0];
    assign loc_rdata    = apt_rdata[1];

    for (genvar i = 0; i < NAPT; i++) begin : g_apt
        msgu_apt_port u_apt (
            .clk   (clk),
            .rst   (rst),
            .mu_en (mu_en),
            .addr  (apt_addr[i]),
            .be    (apt_be[i]),
            .we    (apt_we[i]),
            .wdata (apt_wdata[i]),
            .regs  (regs),
            .req   (apt_req[i]),
            .rdata (apt_rdata[i])
        );
    end

    msgu_win_port #(
        .OFS_W (WIN_OFS_W),
        .DW    (WIN_DW)
    ) u_win (
        .clk   (clk),
        .rst   (rst),
        .mu_en (mu_en),
        .addr  (win_addr),
        .be    (win_be),
        .we    (win_we),
        .wdata (win_wdata),
        .regs  (regs),
        .req   (win_req),
        .rdata (win_rdata)
    );

    msgu_reg_core u_core (
        .clk           (clk),
        .rst           (rst),
        .post_nonempty (post_nonempty),
        .hreq          (apt_req[0]),
        .wreq          (win_req),
        .lreq          (apt_req[1]),
        .regs          (regs),
        .int0_n        (int0_n)
    );

endmodule

// File: rtl/msgu_irq_regs_chk.sv
module msgu_irq_regs_chk
    import msgu_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        mu_en,
    input logic        post_nonempty,
    input logic        int0_n,
    input logic [31:0] win_rdata,
    input logic        mask_q,
    input logic        stat_q,
    input wreq_t       hreq,
    input wreq_t       wreq,
    input wreq_t       lreq
);

    AST_STAT_SET: assert property (@(posedge clk) disable iff (rst)
        post_nonempty |=> stat_q);  // R2

    AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !post_nonempty |=> !stat_q);  // R2

    AST_IRQ_ASSERT: assert property (@(posedge clk) disable iff (rst)
        (post_nonempty && !mask_q) |=> !int0_n);  // R3

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        mask_q |=> int0_n);  // R3

    AST_WIN_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (win_rdata & ~32'h0000_0008) == 32'h0);  // R4

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(hreq.mask_we || wreq.mask_we || lreq.mask_we) |=> $stable(mask_q));  // R5

    AST_WIN_OFF: assert property (@(posedge clk) disable iff (rst)
        !mu_en |=> (win_rdata == 32'h0));  // R7

    AST_HOST_FIRST: assert property (@(posedge clk) disable iff (rst)
        hreq.mask_we |=> (mask_q == $past(hreq.mask_val)));  // R9

endmodule

bind msgu_irq_regs msgu_irq_regs_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .mu_en         (mu_en),
    .post_nonempty (post_nonempty),
    .int0_n        (int0_n),
    .win_rdata     (win_rdata),
    .mask_q        (regs.mask),
    .stat_q        (regs.stat),
    .hreq          (apt_req[0]),
    .wreq          (win_req),
    .lreq          (apt_req[1])
);

// File: tb/sim_msgu_irq_regs.sv
module sim_msgu_irq_regs;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mu_en = 1'b0;
    logic        post_nonempty = 1'b0;
    logic [15:0] win_addr = '0;
    logic [3:0]  win_be = '0;
    logic        win_we = 1'b0;
    logic [31:0] win_wdata = '0;
    logic [31:0] win_rdata;
    logic [7:0]  hst_addr = '0;
    logic        hst_be = 1'b0;
    logic        hst_we = 1'b0;
    logic [7:0]  hst_wdata = '0;
    logic [7:0]  hst_rdata;
    logic [7:0]  loc_addr = '0;
    logic        loc_be = 1'b0;
    logic        loc_we = 1'b0;
    logic [7:0]  loc_wdata = '0;
    logic [7:0]  loc_rdata;
    logic        int0_n;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msgu_irq_regs u0 (
        .clk(clk), .rst(rst), .mu_en(mu_en), .post_nonempty(post_nonempty),
        .win_addr(win_addr), .win_be(win_be), .win_we(win_we),
        .win_wdata(win_wdata), .win_rdata(win_rdata),
        .hst_addr(hst_addr), .hst_be(hst_be), .hst_we(hst_we),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .loc_addr(loc_addr), .loc_be(loc_be), .loc_we(loc_we),
        .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
        .int0_n(int0_n)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic wwin(input logic [15:0] a, input logic [31:0] d, input logic [3:0] b);
        @(negedge clk);
        win_addr = a; win_wdata = d; win_be = b; win_we = 1'b1;
        @(negedge clk);
        win_we = 1'b0;
    endtask

    task automatic whst(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        hst_addr = a; hst_wdata = d; hst_be = 1'b1; hst_we = 1'b1;
        @(negedge clk);
        hst_we = 1'b0;
    endtask

    task automatic wloc(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        loc_addr = a; loc_wdata = d; loc_be = 1'b1; loc_we = 1'b1;
        @(negedge clk);
        loc_we = 1'b0;
    endtask

    task automatic rwin(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        win_addr = a; win_we = 1'b0;
        @(negedge clk);
        d = win_rdata;
    endtask

    task automatic rhst(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        hst_addr = a; hst_we = 1'b0;
        @(negedge clk);
        d = hst_rdata;
    endtask

    task automatic rloc(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        loc_addr = a; loc_we = 1'b0;
        @(negedge clk);
        d = loc_rdata;
    endtask

    task automatic setq(input logic v);
        @(negedge clk);
        post_nonempty = v;
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] w;
        logic [7:0]  b;
        chk("R1 int0_n after reset", {31'b0, int0_n}, 32'h1);
        rhst(8'h34, b); chk("R1 mask after reset", {24'b0, b}, 32'h00);
        rhst(8'h30, b); chk("R1 status after reset", {24'b0, b}, 32'h00);
        rloc(8'h40, b); chk("R1 inverted enable after reset", {24'b0, b}, 32'h08);
        rhst(8'h10, b); chk("R1 io base after reset", {24'b0, b}, 32'h00);
        rwin(16'h0030, w); chk("R1 window read after reset", w, 32'h0);
    endtask

    task automatic t_latency;
        @(negedge clk);
        hst_addr = 8'h40;
        @(negedge clk);
        chk("R10 data for presented address", {24'b0, hst_rdata}, 32'h08);
        hst_addr = 8'h34;
        #1;
        chk("R10 no change between edges", {24'b0, hst_rdata}, 32'h08);
        @(negedge clk);
        chk("R10 data after next edge", {24'b0, hst_rdata}, 32'h00);
    endtask

    task automatic t_status;
        logic [31:0] w;
        logic [7:0]  b;
        mu_en = 1'b1;
        setq(1'b1);
        chk("R3 int0_n low when unmasked and nonempty", {31'b0, int0_n}, 32'h0);
        rwin(16'h0030, w); chk("R2 window status set", w, 32'h8);
        rhst(8'h30, b); chk("R2 host aperture status set", {24'b0, b}, 32'h08);
        rloc(8'h44, b); chk("R2 local int-status alias set", {24'b0, b}, 32'h08);
        setq(1'b0);
        chk("R3 int0_n high when empty", {31'b0, int0_n}, 32'h1);
        rwin(16'h0030, w); chk("R2 status not sticky", w, 32'h0);
    endtask

    task automatic t_mask;
        logic [31:0] w;
        wwin(16'h0034, 32'hFFFF_FFFF, 4'hF);
        rwin(16'h0034, w); chk("R4 window mask readback, reserved zero", w, 32'h8);
        setq(1'b1);
        chk("R3 masked line stays high", {31'b0, int0_n}, 32'h1);
        rwin(16'h0030, w); chk("R3 mask does not hide status", w, 32'h8);
        wwin(16'h0034, 32'h0, 4'hE);
        rwin(16'h0034, w); chk("R4 write without byte 0 enable ignored", w, 32'h8);
    endtask

    task automatic t_alias;
        logic [31:0] w;
        logic [7:0]  b;
        rloc(8'h40, b); chk("R5 inverted enable shows mask set", {24'b0, b}, 32'h00);
        whst(8'h40, 8'h08);
        rwin(16'h0034, w); chk("R5 int-config write clears mask", w, 32'h0);
        chk("R5 line asserted after enable via int-config", {31'b0, int0_n}, 32'h0);
        wloc(8'h34, 8'h08);
        rhst(8'h40, b); chk("R5 local mask write seen in int-config", {24'b0, b}, 32'h00);
        chk("R5 line released after local mask", {31'b0, int0_n}, 32'h1);
        wwin(16'h0034, 32'h0, 4'hF);
    endtask

    task automatic t_status_wr;
        logic [31:0] w;
        logic [7:0]  b;
        wwin(16'h0030, 32'h0, 4'hF);
        whst(8'h30, 8'h00);
        wloc(8'h44, 8'h00);
        rwin(16'h0030, w); chk("R6 status write ignored while set", w, 32'h8);
        setq(1'b0);
        wwin(16'h0030, 32'hFFFF_FFFF, 4'hF);
        whst(8'h30, 8'hFF);
        wloc(8'h44, 8'hFF);
        rhst(8'h44, b); chk("R6 status write ignored while clear", {24'b0, b}, 32'h00);
        chk("R6 line stays high", {31'b0, int0_n}, 32'h1);
    endtask

    task automatic t_remap;
        logic [7:0] b;
        mu_en = 1'b0;
        whst(8'h10, 8'h11);
        whst(8'h14, 8'h22);
        wloc(8'h18, 8'h33);
        rhst(8'h10, b); chk("R8 io base at 0x10 in normal mode", {24'b0, b}, 32'h11);
        rloc(8'h14, b); chk("R8 second base at 0x14", {24'b0, b}, 32'h22);
        rhst(8'h18, b); chk("R8 second map at 0x18", {24'b0, b}, 32'h33);
        mu_en = 1'b1;
        rhst(8'h10, b); chk("R8 message base at 0x10", {24'b0, b}, 32'h00);
        rloc(8'h18, b); chk("R8 io base moved to 0x18", {24'b0, b}, 32'h11);
        rhst(8'h14, b); chk("R8 second base hidden", {24'b0, b}, 32'h00);
        whst(8'h10, 8'h5A);
        wloc(8'h14, 8'h77);
        rhst(8'h10, b); chk("R8 message base written", {24'b0, b}, 32'h5A);
        mu_en = 1'b0;
        rhst(8'h14, b); chk("R8 hidden base kept its value", {24'b0, b}, 32'h22);
        rloc(8'h10, b); chk("R8 io base back at 0x10", {24'b0, b}, 32'h11);
        rhst(8'h18, b); chk("R8 map unchanged", {24'b0, b}, 32'h33);
    endtask

    task automatic t_window;
        logic [31:0] w;
        logic [7:0]  b;
        mu_en = 1'b1;
        setq(1'b1);
        rwin(16'h5A30, w); chk("R7 window hit at programmed base", w, 32'h8);
        rwin(16'h0030, w); chk("R7 window miss at other base", w, 32'h0);
        wwin(16'h0034, 32'hFFFF_FFFF, 4'hF);
        rhst(8'h34, b); chk("R7 write at other base ignored", {24'b0, b}, 32'h00);
        mu_en = 1'b0;
        rwin(16'h5A30, w); chk("R7 window off in normal mode", w, 32'h0);
        wwin(16'h5A34, 32'hFFFF_FFFF, 4'hF);
        rhst(8'h34, b); chk("R7 write in normal mode ignored", {24'b0, b}, 32'h00);
    endtask

    task automatic t_prio;
        logic [7:0] b;
        mu_en = 1'b1;
        @(negedge clk);
        hst_addr = 8'h34; hst_wdata = 8'h08; hst_be = 1'b1; hst_we = 1'b1;
        win_addr = 16'h5A34; win_wdata = 32'h0; win_be = 4'hF; win_we = 1'b1;
        loc_addr = 8'h40; loc_wdata = 8'h08; loc_be = 1'b1; loc_we = 1'b1;
        @(negedge clk);
        hst_we = 1'b0; win_we = 1'b0; loc_we = 1'b0;
        rhst(8'h34, b); chk("R9 host wins mask collision", {24'b0, b}, 32'h08);
        wwin(16'h5A34, 32'h0, 4'hF);
        @(negedge clk);
        win_addr = 16'h5A34; win_wdata = 32'h8; win_be = 4'hF; win_we = 1'b1;
        loc_addr = 8'h34; loc_wdata = 8'h00; loc_be = 1'b1; loc_we = 1'b1;
        @(negedge clk);
        win_we = 1'b0; loc_we = 1'b0;
        rloc(8'h34, b); chk("R9 window wins over local", {24'b0, b}, 32'h08);
        mu_en = 1'b0;
        @(negedge clk);
        hst_addr = 8'h14; hst_wdata = 8'h44; hst_be = 1'b1; hst_we = 1'b1;
        loc_addr = 8'h14; loc_wdata = 8'h55; loc_be = 1'b1; loc_we = 1'b1;
        @(negedge clk);
        hst_we = 1'b0; loc_we = 1'b0;
        rloc(8'h14, b); chk("R9 host wins base collision", {24'b0, b}, 32'h44);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_latency();
        t_status();
        t_mask();
        t_alias();
        t_status_wr();
        t_remap();
        t_window();
        t_prio();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule